// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a CPU instruction-fetch port and a 16-bit program memory. While the memory bus has no other work, it reads aligned two-byte words ahead of the execution point and hands them to the CPU one byte at a time, in program order. A small byte store of `DEPTH` entries, four by default, holds the prefetched code. Every memory word occupies the bus for a programmable number of clocks. Each fetch is sized so that the whole word fits in the store when it arrives, so no fetched byte is ever thrown away.

A taken branch is signalled with a flush and the new target address. The flush empties the store, cancels any word still in flight, and restarts fetching at the target. When the target starts at an odd byte, the unwanted low half of the first word is skipped. A branch cache can supply four code bytes with the flush. Those bytes fill the store in a single cycle, and fetching resumes just past them. With the enable input low, the store is bypassed: each CPU byte request causes one memory access, which runs the full wait time and delivers only the requested byte.

Top module: `ifetch_queue`

## Requirements
- R1: After a synchronous reset, `cpu_vld_o` and `mem_req_o` are low. The first clock without reset, with the bus idle, starts a fetch of word address 0, so `mem_req_o` is high with `mem_addr_o` = 0 on the next cycle.
- R2: The store never holds more than `DEPTH` bytes. A fetch starts only when the current fill plus the bytes that word will deliver is at most `DEPTH`, so a full store that is not read keeps `mem_req_o` low.
- R3: Each memory request keeps `mem_req_o` high and `mem_addr_o` constant for exactly W clocks. W is the value of `wait_i` on the clock the fetch is decided, with 0 treated as 1. The word on `mem_rdata_i` is taken on the last of those clocks.
- R4: Bytes reach `cpu_byte_o` in ascending address order. Within a word, bits [7:0] are the even-address byte and bits [15:8] are the odd-address byte. A byte is consumed on each clock where `cpu_vld_o` and `cpu_rdy_i` are both high.
- R5: No new fetch starts on a clock where `bus_busy_i` is high. A fetch already in progress runs to completion.
- R6: `flush_i` without `bc_hit_i` empties the store and cancels any fetch in progress. On the next cycle `cpu_vld_o` and `mem_req_o` are low, and the next fetch reads the word containing `flush_addr_i`.
- R7: When fetching from an odd byte address with the queue enabled, only the high byte of the word is kept, so the first byte delivered after a flush to an odd target is the target byte.
- R8: `flush_i` together with `bc_hit_i` fills the store with the four bytes of `bc_data_i` (bits [7:0] first). These bytes are valid on the next cycle, and fetching resumes at `flush_addr_i` + 4.
- R9: `stall_o` is high exactly when `cpu_rdy_i` is high and no byte is valid.
- R10: With `q_enable_i` low, a fetch starts only while the CPU requests a byte and the store is empty. Each such fetch delivers one byte, the addressed one.
- R11: With W = 4 and the store primed, a CPU that reads one byte every four clocks never sees `stall_o`.
- R12: A flush takes priority over a consume and over a word arriving in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_enable_i | input | 1 | 1: prefetch active; 0: per-byte bypass |
| wait_i | input | WW | Clocks per memory word (0 acts as 1) |
| bus_busy_i | input | 1 | Memory bus claimed by another master |
| flush_i | input | 1 | Taken branch: discard and restart |
| flush_addr_i | input | AW | Branch target byte address |
| bc_hit_i | input | 1 | Branch cache supplies four target bytes |
| bc_data_i | input | DEPTH*8 | Cached bytes, first byte in [7:0] |
| mem_req_o | output | 1 | Memory read active |
| mem_addr_o | output | AW-1 | Word address of the read |
| mem_rdata_i | input | 16 | Memory word |
| cpu_rdy_i | input | 1 | CPU wants a byte |
| cpu_vld_o | output | 1 | Byte on `cpu_byte_o` is valid |
| cpu_byte_o | output | 8 | Next instruction byte |
| stall_o | output | 1 | CPU request with no byte available |

## Verification
The hardest case to reach is a flush that lands in the middle of a long memory access, or on the very clock a word completes, while the CPU is also consuming. A fetch that is cancelled must leave no trace in the byte stream. The bench reaches this with directed sequences that hold `cpu_rdy_i` low under a long wait count and then flush. It follows them with a long random phase that mixes bus-busy pulses, varied wait counts, odd and even targets, cache hits and toggling of the enable. A behavioural model with a byte queue predicts every output on every clock.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    localparam int BYTE_W = 8;

    // How a word fetch is consumed when it completes
    typedef struct packed {
        logic pair;   // keep both bytes of the word
        logic odd;    // first kept byte is the high half
    } pick_t;

    function automatic pick_t choose_pick(input logic full_mode, input logic odd_addr);
        pick_t p;
        p.pair = full_mode && !odd_addr;
        p.odd  = odd_addr;
        return p;
    endfunction

    function automatic int pick_bytes(input pick_t p);
        return p.pair ? 2 : 1;
    endfunction

endpackage

// File: rtl/ifq_store.sv
module ifq_store
    import ifq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      bulk,
    input  logic [DEPTH*BYTE_W-1:0]   bulk_data,
    input  logic                      pop,
    input  logic [1:0]                push_n,
    input  logic [BYTE_W-1:0]         push_lo,
    input  logic [BYTE_W-1:0]         push_hi,
    output logic [BYTE_W-1:0]         head,
    output logic [CW-1:0]             occ
);

    logic [BYTE_W-1:0] slot    [DEPTH];
    logic [BYTE_W-1:0] shifted [DEPTH];
    logic [CW-1:0]     base;

    assign base = occ - CW'(pop);
    assign head = slot[0];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            shifted[i] = (pop && i < DEPTH - 1) ? slot[(i + 1) % DEPTH] : slot[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (bulk) begin
            occ <= CW'(DEPTH);
            for (int i = 0; i < DEPTH; i++) slot[i] <= bulk_data[i*BYTE_W +: BYTE_W];
        end else if (clear) begin
            occ <= '0;
        end else begin
            occ <= base + CW'(push_n);
            for (int i = 0; i < DEPTH; i++) begin
                if (push_n != 2'd0 && base == CW'(i))
                    slot[i] <= push_lo;
                else if (push_n == 2'd2 && base + CW'(1) == CW'(i))
                    slot[i] <= push_hi;
                else
                    slot[i] <= shifted[i];
            end
        end
    end

endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch
    import ifq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int WW         = 4,
    parameter int DEPTH      = 4,
    parameter int CW         = $clog2(DEPTH + 1),
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          busy,
    input  logic          cpu_rdy,
    input  logic [CW-1:0] occ,
    input  logic [WW-1:0] wait_cnt,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    input  logic          bc_hit,
    output logic          mem_req,
    output logic [AW-2:0] mem_addr,
    output logic          done,
    output pick_t         pick
);

    logic [AW-1:0] fptr;
    logic [WW-1:0] cnt, wlat;
    logic          room, start;
    pick_t         pick_n;

    assign pick_n = choose_pick(en, fptr[0]);
    assign room   = en ? (int'(occ) + pick_bytes(pick_n) <= DEPTH)
                       : (occ == '0 && cpu_rdy);
    assign start  = !mem_req && !busy && !flush && room;
    assign done   = mem_req && cnt == wlat && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            fptr     <= RESET_ADDR;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            cnt      <= '0;
            wlat     <= '0;
            pick     <= '0;
        end else if (flush) begin
            mem_req <= 1'b0;
            fptr    <= bc_hit ? flush_addr + AW'(DEPTH) : flush_addr;
        end else if (start) begin
            mem_req  <= 1'b1;
            mem_addr <= fptr[AW-1:1];
            cnt      <= WW'(1);
            wlat     <= (wait_cnt == '0) ? WW'(1) : wait_cnt;
            pick     <= pick_n;
        end else if (mem_req) begin
            if (cnt == wlat) begin
                mem_req <= 1'b0;
                fptr    <= fptr + AW'(pick_bytes(pick));
            end else begin
                cnt <= cnt + WW'(1);
            end
        end
    end

endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
    import ifq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int WW    = 4,
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    q_enable_i,
    input  logic [WW-1:0]           wait_i,
    input  logic                    bus_busy_i,
    input  logic                    flush_i,
    input  logic [AW-1:0]           flush_addr_i,
    input  logic                    bc_hit_i,
    input  logic [DEPTH*8-1:0]      bc_data_i,
    output logic                    mem_req_o,
    output logic [AW-2:0]           mem_addr_o,
    input  logic [15:0]             mem_rdata_i,
    input  logic                    cpu_rdy_i,
    output logic                    cpu_vld_o,
    output logic [7:0]              cpu_byte_o,
    output logic                    stall_o
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] fill_level;
    logic          word_done, take;
    pick_t         cur_pick;
    logic [1:0]    push_n;

    assign cpu_vld_o = fill_level != '0;
    assign stall_o   = cpu_rdy_i && !cpu_vld_o;
    assign take      = cpu_rdy_i && cpu_vld_o && !flush_i;
    assign push_n    = word_done ? 2'(pick_bytes(cur_pick)) : 2'd0;

    ifq_fetch #(.AW(AW), .WW(WW), .DEPTH(DEPTH), .CW(CW)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .en         (q_enable_i),
        .busy       (bus_busy_i),
        .cpu_rdy    (cpu_rdy_i),
        .occ        (fill_level),
        .wait_cnt   (wait_i),
        .flush      (flush_i),
        .flush_addr (flush_addr_i),
        .bc_hit     (bc_hit_i),
        .mem_req    (mem_req_o),
        .mem_addr   (mem_addr_o),
        .done       (word_done),
        .pick       (cur_pick)
    );

    ifq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (flush_i),
        .bulk      (flush_i && bc_hit_i),
        .bulk_data (bc_data_i),
        .pop       (take),
        .push_n    (push_n),
        .push_lo   (cur_pick.odd ? mem_rdata_i[15:8] : mem_rdata_i[7:0]),
        .push_hi   (mem_rdata_i[15:8]),
        .head      (cpu_byte_o),
        .occ       (fill_level)
    );

endmodule

// File: rtl/ifq_checker.sv
module ifq_checker #(
    parameter int AW    = 16,
    parameter int WW    = 4,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               flush_i,
    input logic               bc_hit_i,
    input logic [DEPTH*8-1:0] bc_data_i,
    input logic               bus_busy_i,
    input logic [WW-1:0]      wait_i,
    input logic               mem_req_o,
    input logic [AW-2:0]      mem_addr_o,
    input logic               cpu_vld_o,
    input logic [7:0]         cpu_byte_o,
    input logic               stall_o,
    input logic [CW-1:0]      fill_level
);

    logic [WW:0]   run_pos;
    logic [WW-1:0] w_expect;

    always_ff @(posedge clk) begin
        if (rst || !mem_req_o) begin
            run_pos  <= (WW+1)'(1);
            w_expect <= (wait_i == '0) ? WW'(1) : wait_i;
        end else begin
            run_pos <= run_pos + (WW+1)'(1);
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(fill_level) <= DEPTH);                                             // R2
    AST_REQ_LENGTH: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && run_pos == {1'b0, w_expect} |=> !mem_req_o);                // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && $past(mem_req_o) |-> $stable(mem_addr_o));                 // R3
    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        bus_busy_i && !mem_req_o |=> !mem_req_o);                               // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_i && !bc_hit_i |=> !cpu_vld_o && !mem_req_o);                     // R6
    AST_BULK_FILL: assert property (@(posedge clk) disable iff (rst)
        flush_i && bc_hit_i |=> cpu_vld_o && cpu_byte_o == $past(bc_data_i[7:0])); // R8
    AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> !cpu_vld_o);                                                // R9

endmodule

bind ifetch_queue ifq_checker #(.AW(AW), .WW(WW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (flush_i),
    .bc_hit_i   (bc_hit_i),
    .bc_data_i  (bc_data_i),
    .bus_busy_i (bus_busy_i),
    .wait_i     (wait_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .cpu_vld_o  (cpu_vld_o),
    .cpu_byte_o (cpu_byte_o),
    .stall_o    (stall_o),
    .fill_level (fill_level)
);

// File: tb/tb_ifetch_queue.sv
module tb_ifetch_queue;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic [3:0]  wt = 4'd4;
    logic        busy = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] faddr = '0;
    logic        hit = 1'b0;
    logic [31:0] bcd = '0;
    logic        mreq;
    logic [14:0] maddr;
    logic [15:0] mdata;
    logic        rdy = 1'b0;
    logic        vld;
    logic [7:0]  cbyte;
    logic        stall;

    int vectors = 0, fails = 0, cyc = 0;
    bit chk_on = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mbyte(input int a);
        return 8'(((a * 37) + 11) ^ (a >> 8));
    endfunction

    assign mdata = {mbyte(int'(maddr) * 2 + 1), mbyte(int'(maddr) * 2)};

    ifetch_queue dut (
        .clk(clk), .rst(rst), .q_enable_i(en), .wait_i(wt), .bus_busy_i(busy),
        .flush_i(flush), .flush_addr_i(faddr), .bc_hit_i(hit), .bc_data_i(bcd),
        .mem_req_o(mreq), .mem_addr_o(maddr), .mem_rdata_i(mdata),
        .cpu_rdy_i(rdy), .cpu_vld_o(vld), .cpu_byte_o(cbyte), .stall_o(stall)
    );

    // Behavioural reference model
    logic [7:0] mq[$];
    int m_fptr = 0, m_acc = 0, m_cnt = 0, m_wl = 0, m_start = 0, m_n = 0;
    int occ0, need;
    bit fin;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mq.delete(); m_fptr = 0; m_acc = 0;
        end else if (flush) begin
            mq.delete(); m_acc = 0;
            if (hit) begin
                for (int k = 0; k < 4; k++) mq.push_back(bcd[k*8 +: 8]);
                m_fptr = (int'(faddr) + 4) & 16'hFFFF;
            end else m_fptr = int'(faddr);
        end else begin
            occ0 = mq.size();
            fin = 1'b0;
            if (!m_acc) begin
                need = en ? ((m_fptr % 2) ? 1 : 2) : 1;
                if (!busy && (en ? (occ0 + need <= 4) : (occ0 == 0 && rdy))) begin
                    m_acc = 1; m_cnt = 1; m_wl = (wt == 0) ? 1 : int'(wt);
                    m_start = m_fptr; m_n = need;
                end
            end else if (m_cnt == m_wl) fin = 1'b1;
            else m_cnt++;
            if (rdy && occ0 > 0) void'(mq.pop_front());
            if (fin) begin
                for (int k = 0; k < m_n; k++) mq.push_back(mbyte(m_start + k));
                m_fptr = (m_fptr + m_n) & 16'hFFFF;
                m_acc = 0;
            end
        end
        chk_on = 1'b1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !rst) begin
            vectors++;
            if (vld !== (mq.size() > 0)) begin
                fails++; $display("FAIL R4 valid: actual %0b expected %0b", vld, mq.size() > 0);
            end else if (vld && cbyte !== mq[0]) begin
                fails++; $display("FAIL R4 byte: actual %02h expected %02h", cbyte, mq[0]);
            end
            if (stall !== (rdy && mq.size() == 0)) begin
                fails++; $display("FAIL R9 stall: actual %0b expected %0b", stall, rdy && mq.size() == 0);
            end
            if (mreq !== (m_acc != 0)) begin
                fails++; $display("FAIL R3 request: actual %0b expected %0b", mreq, m_acc != 0);
            end else if (mreq && int'(maddr) != (m_start >> 1)) begin
                fails++; $display("FAIL R3 address: actual %0h expected %0h", maddr, m_start >> 1);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_flush(input logic [15:0] a, input logic h, input logic [31:0] d);
        flush = 1'b1; faddr = a; hit = h; bcd = d;
        tick(1);
        flush = 1'b0; hit = 1'b0;
    endtask

    int stalls;

    initial begin
        tick(3);
        rst = 1'b0;
        check(!vld && !mreq, "R1 reset idle", {vld, mreq}, 0);
        tick(1);
        check(mreq && maddr == 0, "R1 first fetch", int'(maddr), 0);

        // continuous consumption at several wait counts
        rdy = 1'b1; wt = 4'd1; tick(60);
        wt = 4'd5; tick(60);
        wt = 4'd0; tick(40);

        // full store blocks further fetches
        rdy = 1'b0; wt = 4'd3; tick(40);
        check(!mreq && vld, "R2 full store no fetch", mreq, 0);

        // R11: one byte every four clocks with W = 4
        wt = 4'd4; do_flush(16'h0100, 1'b0, '0);
        tick(12);
        stalls = 0;
        for (int k = 0; k < 160; k++) begin
            rdy = (k % 4 == 0);
            @(negedge clk); if (stall) stalls++;
            tick(1);
        end
        rdy = 1'b0;
        check(stalls == 0, "R11 no stall at W=4", stalls, 0);

        // R5: busy bus blocks fetch start
        busy = 1'b1; do_flush(16'h0200, 1'b0, '0);
        tick(30);
        check(!mreq, "R5 busy holds off fetch", mreq, 0);
        busy = 1'b0; tick(1);
        check(mreq && maddr == 15'h100, "R5 fetch after busy", int'(maddr), 'h100);

        // R6: flush in the middle of a long access
        wt = 4'd6; tick(8); tick(3);
        do_flush(16'h0300, 1'b0, '0);
        check(!vld && !mreq, "R6 flush clears", {vld, mreq}, 0);
        tick(1);
        check(mreq && maddr == 15'h180, "R6 refetch target", int'(maddr), 'h180);

        // R7: odd branch target
        wt = 4'd2; do_flush(16'h0401, 1'b0, '0);
        tick(6);
        check(vld && cbyte == mbyte('h401), "R7 odd target byte", cbyte, mbyte('h401));

        // R8: branch cache bulk load
        do_flush(16'h0500, 1'b1, 32'hD4C3B2A1);
        check(vld && cbyte == 8'hA1, "R8 bulk first byte", cbyte, 'hA1);
        rdy = 1'b1; tick(1);
        check(vld && cbyte == 8'hB2, "R8 bulk second byte", cbyte, 'hB2);
        tick(2);
        check(mreq && maddr == 15'h282, "R8 resume past cached bytes", int'(maddr), 'h282);

        // R12: flush on a completing word while consuming (covered by model compare)
        wt = 4'd1; tick(2); do_flush(16'h0700, 1'b0, '0); tick(3);
        do_flush(16'h0703, 1'b0, '0); tick(4);

        // random mixed traffic, enabled
        for (int k = 0; k < 600; k++) begin
            rdy  = ($urandom % 3) != 0;
            busy = ($urandom % 5) == 0;
            wt   = 4'($urandom % 6);
            if ($urandom % 23 == 0) do_flush(16'($urandom), 1'($urandom % 2), $urandom);
            else tick(1);
        end
        busy = 1'b0;

        // R10: bypass mode
        en = 1'b0; rdy = 1'b0; do_flush(16'h0600, 1'b0, '0);
        tick(10);
        check(!mreq && !vld, "R10 bypass idle without request", mreq, 0);
        rdy = 1'b1; wt = 4'd3; tick(100);
        for (int k = 0; k < 600; k++) begin
            en   = ($urandom % 4) != 0;
            rdy  = ($urandom % 2) != 0;
            busy = ($urandom % 6) == 0;
            wt   = 4'($urandom % 5);
            if ($urandom % 31 == 0) do_flush(16'($urandom), 1'($urandom % 2), $urandom);
            else tick(1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule